// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a general-purpose I/O port that sits behind a simple 32-bit register bus. Software decides, pin by pin, whether each pad is driven or observed. It can change the driven values in three ways: by writing the whole output-value register, or by writing a one-hot or multi-bit mask to a set register or to a clear register. The set and clear registers update only the bits named in the mask, so two agents can change different pins without a read-modify-write race.

The block drives a value and an output enable for every pad. Pad levels pass through a two-stage synchronizer before software can read them. Accesses are single-cycle. A write takes effect at the clock edge that samples it. Read data is combinational from the addressed register, so it is valid in the cycle the read is presented. The pin count is a parameter and defaults to 32.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the output-value register and the direction register are 0, so `pad_out` and `pad_oe` are all 0 and reads of offsets 0x00 and 0x08 return 0.
- R2: A write to byte offset 0x08 loads the direction register at the next clock edge. A 1 in bit n drives `pad_oe[n]` high, making pin n an output. A 0 makes it an input. The value reads back at 0x08.
- R3: A write to offset 0x10 sets to 1 every output-value bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x14 clears to 0 every output-value bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R5: A write to offset 0x00 replaces the whole output-value register. The register reads back at 0x00 and appears on `pad_out` from the next cycle.
- R6: A read of offset 0x04 returns the pad levels with bit n for pin n, delayed by two clock edges through the synchronizer. A change presented before edge k is readable after edge k+1 and not before.
- R7: Reads of offsets 0x0C, 0x10, 0x14, any offset above 0x14, and any address whose low two bits are non-zero return 0.
- R8: Writes to offset 0x04, offset 0x0C, offsets above 0x14, or addresses whose low two bits are non-zero change neither `pad_out` nor `pad_oe`.
- R9: The output-value register updates while a pin is an input. `pad_out` follows it regardless of direction, so the value is already present when the pin is switched to output.
- R10: When `bus_sel` is low, `bus_wr`, `bus_addr` and `bus_wdata` have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (5) | Byte address; bits [1:0] must be 0 for a mapped access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register, 0 when unmapped |
| pad_in | input | PIN_N (32) | Asynchronous pad levels |
| pad_out | output | PIN_N (32) | Value driven on each pad |
| pad_oe | output | PIN_N (32) | Per-pad output enable, 1 = drive |

## Verification
On every cycle, the embedded properties check how each write class moves the port outputs. They cover masked set and clear, full-register loads, direction loads, ignored offsets and deselected cycles. They also check that unmapped reads return zero and that the input register equals the pad level of two edges earlier. Only the bench scenarios can show a value parked on an input pin appearing once the direction flips, the exact cycle in which a pad change becomes readable, and read-back of every register after sequences of mixed writes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // word index of each register (byte offset / 4); the map order is fixed
    localparam int WORD_DATA = 0;
    localparam int WORD_PIN  = 1;
    localparam int WORD_DIR  = 2;
    localparam int WORD_RSVD = 3;
    localparam int WORD_SET  = 4;
    localparam int WORD_CLR  = 5;

    // synchronizer depth on the pad inputs
    localparam int SYNC_STAGES = 2;

    // one-hot register hit vector from the decoder
    typedef struct packed {
        logic data;
        logic pin;
        logic dir;
        logic set;
        logic clr;
    } gpio_hit_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output gpio_hit_t         hit
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;

    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        aligned  = (bus_addr[1:0] == 2'b00);
        hit.data = aligned && (word_idx == IDX_W'(WORD_DATA));
        hit.pin  = aligned && (word_idx == IDX_W'(WORD_PIN));
        hit.dir  = aligned && (word_idx == IDX_W'(WORD_DIR));
        hit.set  = aligned && (word_idx == IDX_W'(WORD_SET));
        hit.clr  = aligned && (word_idx == IDX_W'(WORD_CLR));
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
    import gpio_port_pkg::*;
#(
    parameter int PIN_N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] pad_in,
    output logic [PIN_N-1:0] pin_sync
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][PIN_N-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.stg[0] = pad_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.stg[SYNC_STAGES-1];

    // edges seen since reset, saturating; lets the latency check start cleanly
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R6: the synchronized value is the pad level of SYNC_STAGES edges ago
    a_r6_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'(SYNC_STAGES)) |-> (pin_sync == $past(pad_in, SYNC_STAGES)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PIN_N  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  gpio_hit_t         hit,
    input  logic [PIN_N-1:0]  pin_sync,
    output logic [PIN_N-1:0]  out_val,
    output logic [PIN_N-1:0]  dir_val,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic [PIN_N-1:0] outv;
        logic [PIN_N-1:0] dir;
    } reg_state_t;

    reg_state_t       rs_d, rs_q;
    logic [PIN_N-1:0] wmask;
    logic             wr_en;

    always_comb begin
        wmask = bus_wdata[PIN_N-1:0];
        wr_en = bus_sel && bus_wr;
        rs_d  = rs_q;
        if (wr_en) begin
            if (hit.data) rs_d.outv = wmask;
            if (hit.set)  rs_d.outv = rs_q.outv | wmask;
            if (hit.clr)  rs_d.outv = rs_q.outv & ~wmask;
            if (hit.dir)  rs_d.dir  = wmask;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit.data) bus_rdata = DATA_W'(rs_q.outv);
        if (hit.pin)  bus_rdata = DATA_W'(pin_sync);
        if (hit.dir)  bus_rdata = DATA_W'(rs_q.dir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign out_val = rs_q.outv;
    assign dir_val = rs_q.dir;

    // R7: set, clear, reserved, unaligned and out-of-map reads return zero
    a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[1:0] != 2'b00) || (bus_addr == ADDR_W'('h0C)) ||
         (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14)) ||
         (bus_addr > ADDR_W'('h14))) |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PIN_N  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe
);

    gpio_hit_t        hit;
    logic [PIN_N-1:0] pin_sync;

    gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    gpio_port_sync #(.PIN_N(PIN_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_port_regs #(
        .PIN_N  (PIN_N),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .pin_sync  (pin_sync),
        .out_val   (pad_out),
        .dir_val   (pad_oe),
        .bus_rdata (bus_rdata)
    );

    logic wr_cyc;
    assign wr_cyc = bus_sel && bus_wr;

    // R5: full-register write lands on the pads one edge later
    a_r5_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == ADDR_W'('h00)) |=> (pad_out == $past(bus_wdata[PIN_N-1:0])));

    // R2: direction write lands on the enables one edge later
    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == ADDR_W'('h08)) |=> (pad_oe == $past(bus_wdata[PIN_N-1:0])));

    // R3: masked set raises masked bits, keeps the rest
    a_r3_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == ADDR_W'('h10)) |=>
        (pad_out == ($past(pad_out) | $past(bus_wdata[PIN_N-1:0]))));

    // R4: masked clear drops masked bits, keeps the rest
    a_r4_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && bus_addr == ADDR_W'('h14)) |=>
        (pad_out == ($past(pad_out) & ~$past(bus_wdata[PIN_N-1:0]))));

    // R8: writes to read-only, reserved, unaligned or out-of-map addresses are dropped
    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && ((bus_addr == ADDR_W'('h04)) || (bus_addr == ADDR_W'('h0C)) ||
                    (bus_addr > ADDR_W'('h14)) || (bus_addr[1:0] != 2'b00)))
        |=> ($stable(pad_out) && $stable(pad_oe)));

    // R10: a deselected cycle changes nothing
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R2: direction only moves on a direction write
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cyc && bus_addr == ADDR_W'('h08)) |=> $stable(pad_oe));

endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

    localparam int PIN_N  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [PIN_N-1:0]  pad_in = '0;
    logic [PIN_N-1:0]  pad_out;
    logic [PIN_N-1:0]  pad_oe;

    always #2.5 clk = ~clk;

    gpio_port_ctrl #(.PIN_N(PIN_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    typedef struct {
        int          kind;   // 1 = read data, 2 = pad outputs
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       mon_kind = 0;
    int       n_checks = 0;
    int       n_fails = 0;
    bit       finished = 1'b0;

    // monitor: compares mid-cycle, when all state is settled
    always @(negedge clk) begin
        if (mon_kind != 0) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL scoreboard: actual empty queue expected an item");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (it.kind == 1) begin
                    if (bus_rdata !== it.exp_a) begin
                        n_fails++;
                        $display("FAIL %s: actual rdata %h expected %h", it.tag, bus_rdata, it.exp_a);
                    end
                end else begin
                    if (pad_out !== it.exp_a || pad_oe !== it.exp_b) begin
                        n_fails++;
                        $display("FAIL %s: actual out %h oe %h expected out %h oe %h",
                                 it.tag, pad_out, pad_oe, it.exp_a, it.exp_b);
                    end
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.kind = 1; it.exp_a = e; it.exp_b = '0; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; mon_kind = 1;
        step();
        bus_sel = 1'b0; mon_kind = 0;
    endtask

    task automatic pin_chk(input logic [31:0] eo, input logic [31:0] ee, input string tag);
        sb_item_t it;
        it.kind = 2; it.exp_a = eo; it.exp_b = ee; it.tag = tag;
        sb_q.push_back(it);
        mon_kind = 2;
        step();
        mon_kind = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            if (sb_q.size() != 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
            end
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1: reset state
        pin_chk(32'h0, 32'h0, "R1 pads after reset");
        rd_chk(5'h00, 32'h0, "R1 data reads 0");
        rd_chk(5'h08, 32'h0, "R1 dir reads 0");

        // R5 / R9: full write while all pins are inputs
        wr_reg(5'h00, 32'hA5A5_5A5A);
        pin_chk(32'hA5A5_5A5A, 32'h0, "R9 value present while input");
        rd_chk(5'h00, 32'hA5A5_5A5A, "R5 data readback");

        // R2: direction
        wr_reg(5'h08, 32'hFFFF_0000);
        pin_chk(32'hA5A5_5A5A, 32'hFFFF_0000, "R2 oe follows dir");
        rd_chk(5'h08, 32'hFFFF_0000, "R2 dir readback");

        // R3: set mask
        wr_reg(5'h10, 32'h0000_00F0);
        pin_chk(32'hA5A5_5AFA, 32'hFFFF_0000, "R3 set mask");
        wr_reg(5'h10, 32'h0000_0000);
        rd_chk(5'h00, 32'hA5A5_5AFA, "R3 zero mask keeps bits");

        // R4: clear mask
        wr_reg(5'h14, 32'hA000_0000);
        pin_chk(32'h05A5_5AFA, 32'hFFFF_0000, "R4 clear mask");
        rd_chk(5'h00, 32'h05A5_5AFA, "R4 data after clear");

        // R7: zero reads
        rd_chk(5'h0C, 32'h0, "R7 reserved reads 0");
        rd_chk(5'h10, 32'h0, "R7 set reads 0");
        rd_chk(5'h14, 32'h0, "R7 clear reads 0");
        rd_chk(5'h18, 32'h0, "R7 out of map reads 0");
        rd_chk(5'h01, 32'h0, "R7 unaligned reads 0");

        // R8: ignored writes
        wr_reg(5'h04, 32'hFFFF_FFFF);
        wr_reg(5'h0C, 32'hFFFF_FFFF);
        wr_reg(5'h1C, 32'hFFFF_FFFF);
        wr_reg(5'h02, 32'hFFFF_FFFF);
        pin_chk(32'h05A5_5AFA, 32'hFFFF_0000, "R8 ignored writes");
        rd_chk(5'h04, 32'h0, "R8 input reg untouched");

        // R10: deselected write strobe
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'hFFFF_FFFF;
        step();
        bus_addr = 5'h08;
        step();
        bus_wr = 1'b0;
        pin_chk(32'h05A5_5AFA, 32'hFFFF_0000, "R10 no effect without select");

        // R6: synchronizer latency
        pad_in = 32'h1234_5678;
        rd_chk(5'h04, 32'h0, "R6 not visible after 0 edges");
        rd_chk(5'h04, 32'h0, "R6 not visible after 1 edge");
        rd_chk(5'h04, 32'h1234_5678, "R6 visible after 2 edges");
        pad_in = 32'h8000_0001;
        step();
        step();
        rd_chk(5'h04, 32'h8000_0001, "R6 end bits map to pins");

        // R9: park value, then switch to output
        wr_reg(5'h14, 32'hFFFF_FFFF);
        wr_reg(5'h08, 32'h0000_0000);
        pin_chk(32'h0, 32'h0, "R4 clear all");
        wr_reg(5'h00, 32'h0000_C3C3);
        pin_chk(32'h0000_C3C3, 32'h0, "R9 parked on inputs");
        wr_reg(5'h08, 32'h0000_FFFF);
        pin_chk(32'h0000_C3C3, 32'h0000_FFFF, "R9 value driven after dir flip");

        step();
        finish_run();
    end

endmodule